// File: doc/BRIEF.md
# Programmable Product-Term Macrocell

This block is one logic cell of an erasable programmable logic device. A set of sum terms, each an AND of chosen true or inverted bits of a shared input bus, is ORed together with any chosen members of a pool of expander terms that a cell group shares. The sum passes a programmable inverter and then goes to the pad either directly or through a storage element. Static configuration inputs pick the literals of every term, the inversion, whether the storage element loads or toggles, which clock and which clock edge it uses, whether the pad sees the stored or the direct value, and what goes back to the routing array.

Three extra product terms, built the same way as the sum terms, serve the cell itself: one is the local clock, one is an asynchronous clear of the storage element, and one is the pad's output enable. The pad driver sits in the I/O ring; this block hands it a value and an enable and reads the resolved pad level back on `pad_i`. The feedback output goes to the device routing array, which lies outside this block, as does the loading of the configuration bits.

Top module: `pterm_macrocell`

## Requirements
- R1: Term k uses bit k*N_IN+j of `lit_true_i` to require input bit j high and the same bit of `lit_comp_i` to require it low; the term is the AND of its required literals, and a term with no literal enabled is 0.
- R2: The direct value equals the OR of sum terms 0 to N_SUM-1 and of every expander bit e with `exp_sel_i[e]` high, XORed with `cfg_invert_i`.
- R3: `pad_o` carries the direct value when `cfg_reg_out_i` is 0 and the stored value when it is 1.
- R4: With `cfg_toggle_i` 0 the stored value takes the direct value at each active clock edge; with it 1 the stored value inverts at an active edge when the direct value is 1 and holds when it is 0.
- R5: With `cfg_fall_edge_i` 0 the active edge is the rising edge of the chosen clock; with it 1 it is the falling edge, and the other edge leaves the stored value unchanged.
- R6: With `cfg_local_clk_i` 0 the chosen clock is `clk_i`; with it 1 the chosen clock is term N_SUM, and `clk_i` edges have no effect on the stored value.
- R7: While term N_SUM+1 is 1 the stored value is 0 at once, without a clock edge, and it stays 0 through active edges.
- R8: `pad_oe_o` equals term N_SUM+2, so a cell whose enable term has no literals leaves its pad released.
- R9: `fb_o` is the direct value when `cfg_fb_sel_i` is 0, the stored value when it is 1, and the level on `pad_i` when it is 2 or 3, which with the enable low is whatever drives the pad from outside.
- R10: While `rst_n_i` is low the stored value is 0; after `rst_n_i` rises it stays 0 through the first two rising edges of `clk_i`, and the third one is the first that can load it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Global clock, also clocks the reset synchronizer |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| in_bus_i | input | N_IN | Shared input bus the terms draw literals from |
| exp_terms_i | input | N_EXP | Shared expander term values of the cell group |
| exp_sel_i | input | N_EXP | Per expander: 1 ORs it into this cell's sum |
| lit_true_i | input | (N_SUM+3)*N_IN | True-literal enables, N_IN bits per term |
| lit_comp_i | input | (N_SUM+3)*N_IN | Complement-literal enables, N_IN bits per term |
| cfg_invert_i | input | 1 | Inverts the sum |
| cfg_toggle_i | input | 1 | 0 load, 1 toggle storage behaviour |
| cfg_fall_edge_i | input | 1 | 0 rising, 1 falling active edge |
| cfg_local_clk_i | input | 1 | 0 global clock, 1 product-term clock |
| cfg_reg_out_i | input | 1 | 0 direct, 1 stored value to the pad |
| cfg_fb_sel_i | input | 2 | Feedback source: 0 direct, 1 stored, 2/3 pad |
| pad_i | input | 1 | Resolved pad level |
| pad_o | output | 1 | Value for the pad driver |
| pad_oe_o | output | 1 | Pad driver enable |
| fb_o | output | 1 | Feedback to the routing array |

## Verification
The direct value, the pad enable and every feedback choice other than the stored one settle within the same cycle as their inputs, so the bench drives on the falling edge of `clk_i` and reads them one nanosecond later. The stored value is due one active edge after its data: the bench reads it one nanosecond after that edge, and in falling-edge mode it also reads it after the rising edge to show nothing moved. Clear takes effect with no edge and is read one nanosecond after the clear term rises; after reset release the stored value is read after the first, second and third rising edges, which are the points where R10 places its changes.

// File: rtl/pterm_mc_pkg.sv
package pterm_mc_pkg;

  typedef enum logic [1:0] {
    FB_COMB = 2'd0,
    FB_REG  = 2'd1,
    FB_PIN  = 2'd2,
    FB_PIN2 = 2'd3
  } fb_sel_e;

  typedef struct packed {
    logic toggle;
    logic fall_edge;
    logic local_clk;
  } store_cfg_t;

endpackage

// File: rtl/pterm_and.sv
module pterm_and #(
  parameter int unsigned N_IN = 8
) (
  input  logic [N_IN-1:0] lits_i,
  input  logic [N_IN-1:0] t_en_i,
  input  logic [N_IN-1:0] c_en_i,
  output logic            term_o
);

  logic [N_IN-1:0] miss;
  logic            used;

  always_comb begin
    miss   = (t_en_i & ~lits_i) | (c_en_i & lits_i);
    used   = |(t_en_i | c_en_i);
    term_o = used & ~(|miss);
  end

endmodule

// File: rtl/pterm_array.sv
module pterm_array #(
  parameter int unsigned N_IN   = 8,
  parameter int unsigned N_TERM = 11,
  localparam int unsigned CFG_W = N_TERM * N_IN
) (
  input  logic [N_IN-1:0]   lits_i,
  input  logic [CFG_W-1:0]  t_en_i,
  input  logic [CFG_W-1:0]  c_en_i,
  output logic [N_TERM-1:0] terms_o
);

  for (genvar k = 0; k < N_TERM; k++) begin : g_term
    pterm_and #(
      .N_IN (N_IN)
    ) u_term (
      .lits_i (lits_i),
      .t_en_i (t_en_i[k*N_IN +: N_IN]),
      .c_en_i (c_en_i[k*N_IN +: N_IN]),
      .term_o (terms_o[k])
    );
  end

endmodule

// File: rtl/exp_select.sv
module exp_select #(
  parameter int unsigned N_EXP = 32
) (
  input  logic [N_EXP-1:0] exp_i,
  input  logic [N_EXP-1:0] sel_i,
  output logic             hit_o
);

  always_comb begin
    hit_o = |(exp_i & sel_i);
  end

endmodule

// File: rtl/mc_reset_sync.sv
module mc_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  output logic rst_sync_n_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/mc_register.sv
module mc_register
  import pterm_mc_pkg::*;
(
  input  logic       gclk_i,
  input  logic       pt_clk_i,
  input  store_cfg_t cfg_i,
  input  logic       d_i,
  input  logic       clr_i,
  output logic       q_o
);

  logic clk_src;
  logic store_clk;
  logic q_next;

  always_comb begin
    clk_src   = cfg_i.local_clk ? pt_clk_i : gclk_i;
    store_clk = clk_src ^ cfg_i.fall_edge;
  end

  always_comb begin
    if (cfg_i.toggle) begin
      q_next = q_o ^ d_i;
    end else begin
      q_next = d_i;
    end
  end

  always_ff @(posedge store_clk or posedge clr_i) begin
    if (clr_i) begin
      q_o <= 1'b0;
    end else begin
      q_o <= q_next;
    end
  end

endmodule

// File: rtl/pterm_macrocell.sv
module pterm_macrocell
  import pterm_mc_pkg::*;
#(
  parameter int unsigned N_IN  = 8,
  parameter int unsigned N_SUM = 8,
  parameter int unsigned N_EXP = 32,
  localparam int unsigned N_TERM   = N_SUM + 3,
  localparam int unsigned TERM_CLK = N_SUM,
  localparam int unsigned TERM_CLR = N_SUM + 1,
  localparam int unsigned TERM_OE  = N_SUM + 2,
  localparam int unsigned CFG_W    = N_TERM * N_IN
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic [N_IN-1:0]  in_bus_i,
  input  logic [N_EXP-1:0] exp_terms_i,
  input  logic [N_EXP-1:0] exp_sel_i,
  input  logic [CFG_W-1:0] lit_true_i,
  input  logic [CFG_W-1:0] lit_comp_i,
  input  logic             cfg_invert_i,
  input  logic             cfg_toggle_i,
  input  logic             cfg_fall_edge_i,
  input  logic             cfg_local_clk_i,
  input  logic             cfg_reg_out_i,
  input  logic [1:0]       cfg_fb_sel_i,
  input  logic             pad_i,
  output logic             pad_o,
  output logic             pad_oe_o,
  output logic             fb_o
);

  logic [N_TERM-1:0] terms;
  logic              exp_hit;
  logic              sop;
  logic              comb_val;
  logic              clk_term;
  logic              clr_term;
  logic              clr_any;
  logic              rst_sync_n;
  logic              q;
  store_cfg_t        store_cfg;

  pterm_array #(
    .N_IN   (N_IN),
    .N_TERM (N_TERM)
  ) u_array (
    .lits_i  (in_bus_i),
    .t_en_i  (lit_true_i),
    .c_en_i  (lit_comp_i),
    .terms_o (terms)
  );

  exp_select #(
    .N_EXP (N_EXP)
  ) u_exp (
    .exp_i (exp_terms_i),
    .sel_i (exp_sel_i),
    .hit_o (exp_hit)
  );

  mc_reset_sync #(
    .STAGES (2)
  ) u_rst (
    .clk_i        (clk_i),
    .rst_n_i      (rst_n_i),
    .rst_sync_n_o (rst_sync_n)
  );

  always_comb begin
    sop      = (|terms[N_SUM-1:0]) | exp_hit;
    comb_val = sop ^ cfg_invert_i;
    clk_term = terms[TERM_CLK];
    clr_term = terms[TERM_CLR];
    clr_any  = clr_term | ~rst_sync_n;
    store_cfg.toggle    = cfg_toggle_i;
    store_cfg.fall_edge = cfg_fall_edge_i;
    store_cfg.local_clk = cfg_local_clk_i;
  end

  mc_register u_store (
    .gclk_i   (clk_i),
    .pt_clk_i (clk_term),
    .cfg_i    (store_cfg),
    .d_i      (comb_val),
    .clr_i    (clr_any),
    .q_o      (q)
  );

  always_comb begin
    pad_o    = cfg_reg_out_i ? q : comb_val;
    pad_oe_o = terms[TERM_OE];
    unique case (fb_sel_e'(cfg_fb_sel_i))
      FB_COMB: fb_o = comb_val;
      FB_REG:  fb_o = q;
      default: fb_o = pad_i;
    endcase
  end

endmodule

// File: rtl/pterm_macrocell_chk.sv
module pterm_macrocell_chk #(
  parameter int unsigned N_IN = 8
) (
  input logic            clk_i,
  input logic            rst_n_i,
  input logic            rst_sync_n,
  input logic            cfg_toggle_i,
  input logic            cfg_fall_edge_i,
  input logic            cfg_local_clk_i,
  input logic            comb_val,
  input logic            clr_term,
  input logic            q,
  input logic [N_IN-1:0] oe_true,
  input logic [N_IN-1:0] oe_comp,
  input logic            pad_oe_o
);

  AST_LOAD_ON_EDGE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (rst_sync_n && !clr_term && !cfg_local_clk_i && !cfg_fall_edge_i && !cfg_toggle_i)
    |=> (q == $past(comb_val)) || (q == 1'b0)); // R4

  AST_TOGGLE_ON_EDGE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (rst_sync_n && !clr_term && !cfg_local_clk_i && !cfg_fall_edge_i && cfg_toggle_i)
    |=> (q == ($past(q) ^ $past(comb_val))) || (q == 1'b0)); // R4

  AST_CLEAR_FORCES_ZERO: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    clr_term |-> (q == 1'b0)); // R7

  AST_ENABLE_UNPROGRAMMED: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    ((oe_true | oe_comp) == '0) |-> !pad_oe_o); // R8

  AST_RESET_HOLDS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !rst_sync_n |-> (q == 1'b0)); // R10

endmodule

bind pterm_macrocell pterm_macrocell_chk #(
  .N_IN (N_IN)
) u_chk (
  .clk_i           (clk_i),
  .rst_n_i         (rst_n_i),
  .rst_sync_n      (rst_sync_n),
  .cfg_toggle_i    (cfg_toggle_i),
  .cfg_fall_edge_i (cfg_fall_edge_i),
  .cfg_local_clk_i (cfg_local_clk_i),
  .comb_val        (comb_val),
  .clr_term        (clr_term),
  .q               (q),
  .oe_true         (lit_true_i[TERM_OE*N_IN +: N_IN]),
  .oe_comp         (lit_comp_i[TERM_OE*N_IN +: N_IN]),
  .pad_oe_o        (pad_oe_o)
);

// File: tb/test_pterm_macrocell.sv
module test_pterm_macrocell;

  localparam int NI = 8;
  localparam int NS = 8;
  localparam int NE = 32;
  localparam int NT = NS + 3;
  localparam int CW = NT * NI;
  localparam int T_CLK = NS;
  localparam int T_CLR = NS + 1;
  localparam int T_OE  = NS + 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NI-1:0] in_bus;
  logic [NE-1:0] exp_t;
  logic [NE-1:0] exp_sel;
  logic [CW-1:0] lit_t;
  logic [CW-1:0] lit_c;
  logic          cfg_inv, cfg_tog, cfg_fall, cfg_lclk, cfg_rout;
  logic [1:0]    cfg_fb;
  logic          ext_drv;
  logic          pad_in;
  logic          pad_out, pad_oe, fb;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  logic q_m;

  always #2 clk = ~clk;

  assign pad_in = pad_oe ? pad_out : ext_drv;

  pterm_macrocell #(
    .N_IN (NI), .N_SUM (NS), .N_EXP (NE)
  ) i_pterm_macrocell (
    .clk_i (clk), .rst_n_i (rst_n), .in_bus_i (in_bus),
    .exp_terms_i (exp_t), .exp_sel_i (exp_sel),
    .lit_true_i (lit_t), .lit_comp_i (lit_c),
    .cfg_invert_i (cfg_inv), .cfg_toggle_i (cfg_tog),
    .cfg_fall_edge_i (cfg_fall), .cfg_local_clk_i (cfg_lclk),
    .cfg_reg_out_i (cfg_rout), .cfg_fb_sel_i (cfg_fb),
    .pad_i (pad_in), .pad_o (pad_out), .pad_oe_o (pad_oe), .fb_o (fb)
  );

  function automatic logic f_term(int k, logic [CW-1:0] t, logic [CW-1:0] c,
                                  logic [NI-1:0] v);
    logic any = 1'b0;
    logic ok  = 1'b1;
    for (int j = 0; j < NI; j++) begin
      if (t[k*NI+j]) begin any = 1'b1; if (!v[j]) ok = 1'b0; end
      if (c[k*NI+j]) begin any = 1'b1; if (v[j])  ok = 1'b0; end
    end
    return any & ok;
  endfunction

  function automatic logic f_comb();
    logic s = 1'b0;
    for (int k = 0; k < NS; k++) s |= f_term(k, lit_t, lit_c, in_bus);
    s |= |(exp_t & exp_sel);
    return s ^ cfg_inv;
  endfunction

  task automatic check(string req, logic act, logic expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, expv, $time);
    end
  endtask

  task automatic set_lit(int k, int j, bit comp);
    if (comp) lit_c[k*NI+j] = 1'b1;
    else      lit_t[k*NI+j] = 1'b1;
  endtask

  task automatic rand_sum_oe();
    lit_t = '0; lit_c = '0;
    for (int k = 0; k < NS; k++) begin
      int n = $urandom % 4;
      for (int m = 0; m < n; m++) set_lit(k, $urandom % NI, bit'($urandom % 2));
    end
    begin
      int n = $urandom % 3;
      for (int m = 0; m < n; m++) set_lit(T_OE, $urandom % NI, bit'($urandom % 2));
    end
  endtask

  // Holds reset, applies store config with a zero sum on term 0 = in[0], releases.
  task automatic restart(logic tog, logic fall, logic lclk);
    @(negedge clk);
    rst_n = 1'b0;
    in_bus = '0; exp_sel = '0; cfg_inv = 1'b0;
    lit_t = '0; lit_c = '0;
    set_lit(0, 0, 1'b0);
    cfg_tog = tog; cfg_fall = fall; cfg_lclk = lclk; cfg_rout = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    q_m = 1'b0;
  endtask

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'h0000_1c5e);
    rst_n = 1'b0; in_bus = '0; exp_t = '0; exp_sel = '0;
    lit_t = '0; lit_c = '0; cfg_inv = 1'b0; cfg_tog = 1'b0; cfg_fall = 1'b0;
    cfg_lclk = 1'b0; cfg_rout = 1'b1; cfg_fb = 2'd1; ext_drv = 1'b0;
    q_m = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check("R10 reset stored value", pad_out, 1'b0);
    check("R8 reset enable unprogrammed", pad_oe, 1'b0);
    check("R9 reset stored feedback", fb, 1'b0);

    // R1 R2 directed: nothing programmed, then inverted
    cfg_rout = 1'b0; in_bus = 8'hFF; #1;
    check("R1 unprogrammed terms give 0", pad_out, 1'b0);
    cfg_inv = 1'b1; #1;
    check("R2 inversion of empty sum", pad_out, 1'b1);
    cfg_inv = 1'b0;
    set_lit(0, 3, 1'b0); set_lit(0, 3, 1'b1); #1;
    check("R1 contradictory term is 0", pad_out, 1'b0);
    lit_t = '0; lit_c = '0;
    set_lit(2, 5, 1'b1); in_bus = 8'h00; #1;
    check("R1 complement literal met", pad_out, 1'b1);
    in_bus = 8'h20; #1;
    check("R1 complement literal not met", pad_out, 1'b0);
    lit_t = '0; lit_c = '0;
    exp_t = 32'h0001_0000; exp_sel = 32'h0000_0001; #1;
    check("R2 unselected expander ignored", pad_out, 1'b0);
    exp_sel = 32'h0001_0000; #1;
    check("R2 selected expander ORed", pad_out, 1'b1);
    exp_sel = '0;

    // R9 pin feedback with enable low
    cfg_fb = 2'd2; ext_drv = 1'b1; #1;
    check("R9 pin feedback released high", fb, 1'b1);
    ext_drv = 1'b0; #1;
    check("R9 pin feedback released low", fb, 1'b0);

    // Random sweep, load on rising global edge, no clear
    rst_n = 1'b1;
    restart(1'b0, 1'b0, 1'b0);
    for (int it = 0; it < 400; it++) begin
      logic ce, pe;
      @(negedge clk);
      rand_sum_oe();
      in_bus  = NI'($urandom);
      exp_t   = $urandom;
      exp_sel = $urandom & $urandom & $urandom;
      cfg_inv  = 1'($urandom);
      cfg_rout = 1'($urandom);
      cfg_fb   = 2'($urandom);
      ext_drv  = 1'($urandom);
      #1;
      ce = f_comb();
      pe = f_term(T_OE, lit_t, lit_c, in_bus);
      check(cfg_rout ? "R3 stored to pad" : "R2 direct to pad", pad_out, cfg_rout ? q_m : ce);
      check("R8 enable term", pad_oe, pe);
      case (cfg_fb)
        2'd0: check("R9 direct feedback", fb, ce);
        2'd1: check("R9 stored feedback", fb, q_m);
        default: check("R9 pad feedback", fb, pe ? (cfg_rout ? q_m : ce) : ext_drv);
      endcase
      @(posedge clk);
      q_m = ce;
    end

    // R4 load mode directed
    restart(1'b0, 1'b0, 1'b0);
    for (int it = 0; it < 30; it++) begin
      logic ce;
      @(negedge clk);
      in_bus = NI'($urandom); #1;
      ce = f_comb();
      @(posedge clk); #1;
      q_m = ce;
      check("R4 load at rising edge", pad_out, q_m);
    end

    // R4 toggle mode
    restart(1'b1, 1'b0, 1'b0);
    for (int it = 0; it < 30; it++) begin
      logic ce;
      @(negedge clk);
      in_bus = NI'($urandom); #1;
      ce = f_comb();
      @(posedge clk); #1;
      q_m = q_m ^ ce;
      check("R4 toggle at rising edge", pad_out, q_m);
    end

    // R10 release timing with data held at 1
    @(negedge clk);
    rst_n = 1'b0; cfg_tog = 1'b0; in_bus = 8'h01;
    repeat (2) @(negedge clk);
    #1; check("R10 zero during reset", pad_out, 1'b0);
    rst_n = 1'b1;
    @(posedge clk); #1; check("R10 no load at first edge", pad_out, 1'b0);
    @(posedge clk); #1; check("R10 no load at second edge", pad_out, 1'b0);
    @(posedge clk); #1; check("R10 load at third edge", pad_out, 1'b1);

    // R5 falling edge
    restart(1'b0, 1'b1, 1'b0);
    for (int it = 0; it < 30; it++) begin
      logic ce;
      @(posedge clk); #1;
      in_bus = NI'($urandom); #1;
      ce = f_comb();
      check("R5 rising edge ignored", pad_out, q_m);
      @(negedge clk); #1;
      q_m = ce;
      check("R5 load at falling edge", pad_out, q_m);
    end

    // R6 product-term clock on in[6]
    restart(1'b0, 1'b0, 1'b1);
    set_lit(T_CLK, 6, 1'b0);
    for (int it = 0; it < 20; it++) begin
      logic dv;
      dv = 1'($urandom);
      @(negedge clk);
      in_bus[0] = dv; #1;
      @(posedge clk); #1;
      check("R6 global edge ignored", pad_out, q_m);
      in_bus[6] = 1'b1; #1;
      q_m = dv;
      check("R6 term clock rising loads", pad_out, q_m);
      in_bus[0] = ~dv; #1;
      in_bus[6] = 1'b0; #1;
      check("R6 term clock falling ignored", pad_out, q_m);
    end
    // R5 with term clock: falling edge of in[6]
    restart(1'b0, 1'b1, 1'b1);
    set_lit(T_CLK, 6, 1'b0);
    in_bus[0] = 1'b1; #1;
    in_bus[6] = 1'b1; #1;
    check("R5 term clock rising ignored", pad_out, 1'b0);
    in_bus[6] = 1'b0; #1;
    check("R5 term clock falling loads", pad_out, 1'b1);

    // R7 clear on in[7]
    restart(1'b0, 1'b0, 1'b0);
    set_lit(T_CLR, 7, 1'b0);
    @(negedge clk); in_bus = 8'h01;
    @(posedge clk); #1;
    check("R7 set before clear", pad_out, 1'b1);
    in_bus[7] = 1'b1; #1;
    check("R7 clear without edge", pad_out, 1'b0);
    @(posedge clk); #1;
    check("R7 clear overrides edge", pad_out, 1'b0);
    @(negedge clk); in_bus[7] = 1'b0; #1;
    check("R7 still zero after clear drops", pad_out, 1'b0);
    @(posedge clk); #1;
    check("R7 loads again after clear", pad_out, 1'b1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule